// File: doc/BRIEF.md
# SDRAM Mode Command Issuer

This block sits between a simple host write port and the command pins of an SDR-SDRAM. The host first stores a mode code in a small mode register. Every later host write into the SDRAM window is then turned into a command. The mode chosen decides which one: a no-operation, a precharge of every bank, an auto-refresh, or a mode-register or extended-mode-register load. In the normal mode the write goes through to the memory pins as an ordinary write.

A timing register gives, in clock cycles, the wait after a precharge, the wait after a refresh and the write recovery. A parameter gives the wait after a mode-register load. While a wait runs, `hready` stays low and the host's next write is held. The mode stays set, so the host can repeat one command by repeating the write, for example for the series of refreshes at power-up. For a mode-register load the SDRAM address and bank lines are taken from the write address, so the host puts the mode settings into that address.

Top module: `sdcmd_issuer`

## Requirements
- R1: After reset, `hready` is 1, the command pins {cs_n,ras_n,cas_n,we_n} show deselect 4'b1111, `sd_dq_oe` is 0 and the mode is normal. The three timing fields reset to all ones.
- R2: A pulse on `mode_wr` stores `mode_val` when the value is one of the valid codes: 0 normal, 1 no-op, 2 precharge all, 3 load mode register, 4 auto-refresh, 5 load extended mode register. The codes 6 and 7 are ignored and the previous mode stays in force.
- R3: In normal mode an accepted write drives WRITE 4'b0100 for one cycle. On that cycle `sd_addr` = haddr[SA_W-1:0], `sd_ba` = haddr[SA_W+BA_W-1:SA_W], `sd_dq` = `hdata` and `sd_dq_oe` = 1. The wait that follows is tWR.
- R4: In mode 1 the block drives NOP 4'b0111 with the address and bank at 0. No wait follows the command.
- R5: In mode 2 the block drives PRECHARGE 4'b0010. Address bit AP_BIT (A10) is 1, all other address bits are 0 and the bank is 0. The wait that follows is tRP.
- R6: In mode 4 the block drives AUTO REFRESH 4'b0001 with the address and bank at 0. The wait that follows is tRFC.
- R7: In modes 3 and 5 the block drives MODE REGISTER SET 4'b0000. The address and bank lines come from the write address. The wait that follows is MRD_CYC cycles.
- R8: A write is taken on the clock edge where `hwr` and `hready` are both 1. The command is on the pins for exactly the next cycle, and deselect is shown at every other time. `hready` then stays low for 1+wait cycles.
- R9: The mode stays set after a command, so writes one after another repeat the same command with the same wait.
- R10: `cfg_data` holds trp in bits [TW-1:0], trfc in [2TW-1:TW] and twr in [3TW-1:2TW]. A write through `cfg_wr` changes the wait of later commands only. A command that has already been accepted keeps the wait it was given.
- R11: In every mode other than normal, the write data is dropped: `sd_dq_oe` stays 0 and `sd_dq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Store mode_val |
| mode_val | input | 3 | Mode code |
| cfg_wr | input | 1 | Store cfg_data |
| cfg_data | input | 3*TW | Timing fields {twr, trfc, trp} |
| hwr | input | 1 | Host write request |
| haddr | input | SA_W+BA_W | Host write address |
| hdata | input | DATA_W | Host write data |
| hready | output | 1 | Block can take a write |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_addr | output | SA_W | SDRAM address lines |
| sd_ba | output | BA_W | SDRAM bank lines |
| sd_dq | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data output enable |

## Verification
The hardest case to reach from the ports is a change to the timing register while a wait is already running. The change must not shorten or stretch the command that is in flight, and only the next command may use the new value. The bench starts a precharge with a long tRP and writes tRP = 0 one cycle after the write is taken. It expects the first stall to keep its long length and the next precharge to stall for a single cycle. An invalid mode code written over a valid mode is checked the same way, by issuing a write afterwards and looking at which command comes out.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        MD_NORMAL = 3'd0,
        MD_NOP    = 3'd1,
        MD_PREALL = 3'd2,
        MD_LMR    = 3'd3,
        MD_REF    = 3'd4,
        MD_ELMR   = 3'd5
    } mode_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_DESEL = 4'b1111;
    localparam cmd_t CMD_NOP   = 4'b0111;
    localparam cmd_t CMD_PRE   = 4'b0010;
    localparam cmd_t CMD_REF   = 4'b0001;
    localparam cmd_t CMD_MRS   = 4'b0000;
    localparam cmd_t CMD_WRITE = 4'b0100;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_CMD  = 2'd1,
        TS_WAIT = 2'd2
    } tstate_e;

    function automatic logic mode_known(input logic [2:0] v);
        return v <= 3'd5;
    endfunction

endpackage

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
    import sdcmd_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_wr,
    input  logic [2:0]      mode_val,
    input  logic            cfg_wr,
    input  logic [3*TW-1:0] cfg_data,
    output mode_e           mode_q,
    output logic [TW-1:0]   trp,
    output logic [TW-1:0]   trfc,
    output logic [TW-1:0]   twr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_NORMAL;
        end else if (mode_wr && mode_known(mode_val)) begin
            mode_q <= mode_e'(mode_val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trp  <= '1;
            trfc <= '1;
            twr  <= '1;
        end else if (cfg_wr) begin
            trp  <= cfg_data[TW-1:0];
            trfc <= cfg_data[2*TW-1:TW];
            twr  <= cfg_data[3*TW-1:2*TW];
        end
    end

endmodule

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int SA_W    = 13,
    parameter int BA_W    = 2,
    parameter int DATA_W  = 16,
    parameter int TW      = 4,
    parameter int AP_BIT  = 10,
    parameter int MRD_CYC = 2
) (
    input  mode_e                 mode_q,
    input  logic [SA_W+BA_W-1:0]  haddr,
    input  logic [DATA_W-1:0]     hdata,
    input  logic [TW-1:0]         trp,
    input  logic [TW-1:0]         trfc,
    input  logic [TW-1:0]         twr,
    output cmd_t                  cmd,
    output logic [SA_W-1:0]       addr,
    output logic [BA_W-1:0]       ba,
    output logic [DATA_W-1:0]     dq,
    output logic                  oe,
    output logic [TW-1:0]         wait_cyc
);

    localparam logic [TW-1:0] MRD_W = TW'(MRD_CYC);

    logic [SA_W-1:0] row_part;
    logic [BA_W-1:0] bank_part;

    assign row_part  = haddr[SA_W-1:0];
    assign bank_part = haddr[SA_W+BA_W-1:SA_W];

    always_comb begin
        cmd      = CMD_NOP;
        addr     = '0;
        ba       = '0;
        dq       = '0;
        oe       = 1'b0;
        wait_cyc = '0;
        unique case (mode_q)
            MD_NORMAL: begin
                cmd      = CMD_WRITE;
                addr     = row_part;
                ba       = bank_part;
                dq       = hdata;
                oe       = 1'b1;
                wait_cyc = twr;
            end
            MD_NOP: begin
                cmd = CMD_NOP;
            end
            MD_PREALL: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
                wait_cyc     = trp;
            end
            MD_REF: begin
                cmd      = CMD_REF;
                wait_cyc = trfc;
            end
            MD_LMR, MD_ELMR: begin
                cmd      = CMD_MRS;
                addr     = row_part;
                ba       = bank_part;
                wait_cyc = MRD_W;
            end
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer
    import sdcmd_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [TW-1:0] wait_in,
    output logic          busy
);

    tstate_e       st;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= TS_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                TS_IDLE: if (accept) begin
                    st  <= TS_CMD;
                    cnt <= wait_in;
                end
                TS_CMD: st <= (cnt == '0) ? TS_IDLE : TS_WAIT;
                TS_WAIT: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == TW'(1)) st <= TS_IDLE;
                end
                default: st <= TS_IDLE;
            endcase
        end
    end

    assign busy = (st != TS_IDLE);

endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
    import sdcmd_pkg::*;
#(
    parameter int SA_W    = 13,
    parameter int BA_W    = 2,
    parameter int DATA_W  = 16,
    parameter int TW      = 4,
    parameter int AP_BIT  = 10,
    parameter int MRD_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_wr,
    input  logic [2:0]            mode_val,
    input  logic                  cfg_wr,
    input  logic [3*TW-1:0]       cfg_data,
    input  logic                  hwr,
    input  logic [SA_W+BA_W-1:0]  haddr,
    input  logic [DATA_W-1:0]     hdata,
    output logic                  hready,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n,
    output logic [SA_W-1:0]       sd_addr,
    output logic [BA_W-1:0]       sd_ba,
    output logic [DATA_W-1:0]     sd_dq,
    output logic                  sd_dq_oe
);

    mode_e           mode_q;
    logic [TW-1:0]   trp, trfc, twr, wait_cyc;
    cmd_t            nxt_cmd, cmd_q;
    logic [SA_W-1:0] nxt_addr;
    logic [BA_W-1:0] nxt_ba;
    logic [DATA_W-1:0] nxt_dq;
    logic            nxt_oe;
    logic            busy, accept;

    sdcmd_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst(rst),
        .mode_wr(mode_wr), .mode_val(mode_val),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .mode_q(mode_q), .trp(trp), .trfc(trfc), .twr(twr)
    );

    sdcmd_decode #(
        .SA_W(SA_W), .BA_W(BA_W), .DATA_W(DATA_W),
        .TW(TW), .AP_BIT(AP_BIT), .MRD_CYC(MRD_CYC)
    ) u_dec (
        .mode_q(mode_q), .haddr(haddr), .hdata(hdata),
        .trp(trp), .trfc(trfc), .twr(twr),
        .cmd(nxt_cmd), .addr(nxt_addr), .ba(nxt_ba),
        .dq(nxt_dq), .oe(nxt_oe), .wait_cyc(wait_cyc)
    );

    sdcmd_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst),
        .accept(accept), .wait_in(wait_cyc), .busy(busy)
    );

    assign hready = !busy;
    assign accept = hwr && !busy;

    // Pin stage: one cycle of command after an accept, deselect otherwise.
    always_ff @(posedge clk) begin
        if (rst || !accept) begin
            cmd_q    <= CMD_DESEL;
            sd_addr  <= '0;
            sd_ba    <= '0;
            sd_dq    <= '0;
            sd_dq_oe <= 1'b0;
        end else begin
            cmd_q    <= nxt_cmd;
            sd_addr  <= nxt_addr;
            sd_ba    <= nxt_ba;
            sd_dq    <= nxt_dq;
            sd_dq_oe <= nxt_oe;
        end
    end

    assign sd_cs_n  = cmd_q.cs_n;
    assign sd_ras_n = cmd_q.ras_n;
    assign sd_cas_n = cmd_q.cas_n;
    assign sd_we_n  = cmd_q.we_n;

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker #(
    parameter int BA_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            hwr,
    input logic            hready,
    input logic            mode_wr,
    input logic [2:0]      mode_val,
    input logic [2:0]      mode_q,
    input logic [BA_W-1:0] haddr_bank,
    input logic            sd_cs_n,
    input logic            sd_ras_n,
    input logic            sd_cas_n,
    input logic            sd_we_n,
    input logic            sd_a10,
    input logic [BA_W-1:0] sd_ba,
    input logic            sd_dq_oe
);

    logic [3:0] pins;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    assert_accept_stalls_R8: assert property (@(posedge clk) disable iff (rst)
        (hwr && hready) |=> !hready);

    assert_idle_deselect_R8: assert property (@(posedge clk) disable iff (rst)
        !(hwr && hready) |=> (pins == 4'b1111));

    assert_cmd_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !sd_cs_n |-> !hready);

    assert_precharge_a10_R5: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0010) |-> sd_a10);

    assert_data_only_normal_R11: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (pins == 4'b0100));

    assert_mrs_bank_from_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (hwr && hready && (mode_q == 3'd3 || mode_q == 3'd5))
        |=> (sd_ba == $past(haddr_bank)));

    assert_bad_mode_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_val > 3'd5) |=> $stable(mode_q));

endmodule

bind sdcmd_issuer sdcmd_checker #(.BA_W(BA_W)) u_chk (
    .clk(clk), .rst(rst), .hwr(hwr), .hready(hready),
    .mode_wr(mode_wr), .mode_val(mode_val), .mode_q(mode_q),
    .haddr_bank(haddr[SA_W+BA_W-1:SA_W]),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_a10(sd_addr[AP_BIT]), .sd_ba(sd_ba), .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdcmd_issuer_test.sv
module sdcmd_issuer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_val = '0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_data = '0;
    logic        hwr = 1'b0;
    logic [14:0] haddr = '0;
    logic [15:0] hdata = '0;
    logic        hready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;
    logic [15:0] sd_dq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sdcmd_issuer uut (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .hwr(hwr), .haddr(haddr),
        .hdata(hdata), .hready(hready), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
        .sd_ba(sd_ba), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [14:0] addr;
        logic [15:0] data;
        logic [3:0]  ecmd;
        logic [12:0] eaddr;
        logic [1:0]  eba;
        logic        eoe;
        logic [15:0] edq;
        logic [7:0]  elow;
    } vec_t;

    // cfg: trp=3, trfc=7, twr=2; MRD_CYC=2
    localparam vec_t VEC [7] = '{
        '{3'd1, 15'h1234, 16'hAAAA, 4'b0111, 13'h0000, 2'd0, 1'b0, 16'h0000, 8'd1}, // R4
        '{3'd2, 15'h7FFF, 16'h5555, 4'b0010, 13'h0400, 2'd0, 1'b0, 16'h0000, 8'd4}, // R5
        '{3'd4, 15'h0000, 16'h1111, 4'b0001, 13'h0000, 2'd0, 1'b0, 16'h0000, 8'd8}, // R6
        '{3'd4, 15'h0005, 16'h2222, 4'b0001, 13'h0000, 2'd0, 1'b0, 16'h0000, 8'd8}, // R9
        '{3'd3, 15'h0022, 16'hCAFE, 4'b0000, 13'h0022, 2'd0, 1'b0, 16'h0000, 8'd3}, // R7
        '{3'd5, 15'h4000, 16'hBEEF, 4'b0000, 13'h0000, 2'd2, 1'b0, 16'h0000, 8'd3}, // R7
        '{3'd0, 15'h2ABC, 16'hCAFE, 4'b0100, 13'h0ABC, 2'd1, 1'b1, 16'hCAFE, 8'd3}  // R3
    };

    logic [3:0]  g_cmd;
    logic [12:0] g_addr;
    logic [1:0]  g_ba;
    logic        g_oe;
    logic [15:0] g_dq;
    int          g_low;

    task automatic check(input string req, input logic ok,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_val = m;
        mode_wr  = 1'b1;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    task automatic set_cfg(input logic [11:0] c);
        @(negedge clk);
        cfg_data = c;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic access(input logic [14:0] a, input logic [15:0] d,
                          input logic chg, input logic [11:0] newcfg);
        @(negedge clk);
        haddr = a;
        hdata = d;
        hwr   = 1'b1;
        while (!hready) @(negedge clk);
        @(negedge clk);
        hwr    = 1'b0;
        g_cmd  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        g_addr = sd_addr;
        g_ba   = sd_ba;
        g_oe   = sd_dq_oe;
        g_dq   = sd_dq;
        if (chg) begin
            cfg_data = newcfg;
            cfg_wr   = 1'b1;
        end
        g_low = 0;
        while (!hready && g_low < 100) begin
            g_low++;
            @(negedge clk);
            cfg_wr = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hready", hready == 1'b1, hready, 1);
        check("R1 pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b1111,
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);
        check("R1 oe", sd_dq_oe == 1'b0, sd_dq_oe, 0);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset mode normal and twr all ones: write stalls 1+15
        access(15'h0001, 16'h0F0F, 1'b0, '0);
        check("R1 default mode write", g_cmd == 4'b0100, g_cmd, 4'b0100);
        check("R1 default twr wait", g_low == 16, g_low, 16);
        // R8 deselect after command
        check("R8 deselect after cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b1111,
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);

        set_cfg({4'd2, 4'd7, 4'd3}); // R10 field layout {twr,trfc,trp}
        for (int i = 0; i < 7; i++) begin
            set_mode(VEC[i].mode);
            access(VEC[i].addr, VEC[i].data, 1'b0, '0);
            check("R3-R9 vector cmd", g_cmd == VEC[i].ecmd, g_cmd, VEC[i].ecmd);
            check("R3-R7 vector addr", g_addr == VEC[i].eaddr, g_addr, VEC[i].eaddr);
            check("R7 vector bank", g_ba == VEC[i].eba, g_ba, VEC[i].eba);
            check("R11 vector oe", g_oe == VEC[i].eoe, g_oe, VEC[i].eoe);
            check("R11 vector dq", g_dq == VEC[i].edq, g_dq, VEC[i].edq);
            check("R8 vector stall length", g_low == int'(VEC[i].elow), g_low, VEC[i].elow);
        end

        // R2 invalid code ignored: precharge mode kept
        set_mode(3'd2);
        set_mode(3'd6);
        access(15'h0000, 16'h0000, 1'b0, '0);
        check("R2 code 6 ignored", g_cmd == 4'b0010, g_cmd, 4'b0010);
        set_mode(3'd7);
        access(15'h0000, 16'h0000, 1'b0, '0);
        check("R2 code 7 ignored", g_cmd == 4'b0010, g_cmd, 4'b0010);

        // R10 cfg change during a running wait
        set_cfg({4'd2, 4'd7, 4'd5});
        access(15'h0000, 16'h0000, 1'b1, {4'd2, 4'd7, 4'd0});
        check("R10 in-flight wait kept", g_low == 6, g_low, 6);
        access(15'h0000, 16'h0000, 1'b0, '0);
        check("R10 new trp=0 used", g_low == 1, g_low, 1);
        check("R5 trp=0 still precharge", g_cmd == 4'b0010, g_cmd, 4'b0010);

        // R9 back-to-back NOPs
        set_mode(3'd1);
        access(15'h7FFF, 16'hFFFF, 1'b0, '0);
        access(15'h7FFF, 16'hFFFF, 1'b0, '0);
        check("R9 repeated NOP", g_cmd == 4'b0111 && g_low == 1, g_cmd, 4'b0111);
        check("R4 NOP drops data", g_oe == 1'b0 && g_dq == 16'h0, g_dq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule